// File: doc/BRIEF.md
# PLL Feedback Divider Ramp Controller

This block changes the feedback divider (N) of a PLL that is already running and locked, without sending the PLL back through a relock. On a start request it takes the requested N, the N currently in use and the comparison frequency, which is the reference frequency divided by M and given in kHz. From the comparison frequency it picks a pair of ramp step coefficients. It then puts the PLL into slowdown mode, loads the new N and triggers the dynamic ramp. After that it polls a ramp-done status once per microsecond, up to a bounded number of polls, and finally leaves slowdown and ramp mode with a single write.

All of the controller's actions on the PLL are write strobes, each carrying field values. The step strobe carries the two step coefficients. The divider strobe carries N. The mode strobe carries the slowdown and dynamic-ramp enables. The microsecond time base comes from a parameterized divider of the system clock. The ramp-done input passes through a synchronizer before it is used. A finished request is reported by a one-cycle done pulse. A timeout flag or a configuration-error flag may accompany that pulse.

Top module: `ndiv_ramp_ctrl`

## Requirements
- R1: When start_i is seen while idle and target_n_i equals cur_n_i, done_o pulses in the next cycle. No strobe of any kind is issued and cfg_err_o stays low, whatever the comparison frequency is.
- R2: The step coefficients depend on the comparison frequency, as follows.
  - 12000, 12800 or 13000 kHz select step A 0x2B and step B 0x0B.
  - 19200 kHz selects A 0x12 and B 0x08.
  - 38400 kHz selects A 0x04 and B 0x05.
  - The step strobe is the first action, in the cycle after start_i.
- R3: Any other comparison frequency is refused. done_o and cfg_err_o pulse together in the cycle after start_i, and no strobe is issued.
- R4: A ramp issues its writes in a fixed order.
  - First the step strobe.
  - Next, one cycle later, a mode write with slowdown 1 and ramp 0.
  - Then a divider write carrying the requested N, exactly one microsecond (TICK_DIV cycles) after the mode write.
  - Then a mode write with slowdown 1 and ramp 1, one microsecond after the divider write.
- R5: Ramp-done is sampled only on microsecond polls. The first poll falls one microsecond after the ramp-enable write. A level raised on ramp_done_i in some cycle is acted on at the first poll that comes at least three cycles later.
- R6: The controller polls at most POLL_MAX times. If ramp-done has not been seen by then, the exit write occurs POLL_MAX microseconds after the ramp-enable write and the request ends with a timeout. A done seen on the final poll is a success.
- R7: Every ramp ends with one mode write that clears slowdown and ramp together. done_o pulses in the following cycle. timeout_o is high only together with that done_o pulse, never before the exit write.
- R8: A start_i that arrives while busy_o is high is ignored. The running ramp keeps its N and its timing.
- R9: Under reset, and right after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a move to target_n_i |
| target_n_i | input | NW | Requested feedback divider |
| cur_n_i | input | NW | Feedback divider currently programmed |
| cmp_khz_i | input | FW | Comparison frequency (reference / M) in kHz |
| ramp_done_i | input | 1 | Asynchronous ramp-finished status from the PLL |
| step_wr_o | output | 1 | Strobe: write step coefficients |
| step_a_o | output | 8 | Step A coefficient |
| step_b_o | output | 8 | Step B coefficient |
| n_wr_o | output | 1 | Strobe: write feedback divider |
| n_val_o | output | NW | Feedback divider value |
| mode_wr_o | output | 1 | Strobe: write slowdown / ramp enables |
| slowdown_o | output | 1 | Slowdown-using-PLL enable field |
| dynramp_o | output | 1 | Dynamic-ramp enable field |
| busy_o | output | 1 | A ramp sequence is in progress |
| done_o | output | 1 | One-cycle pulse: request finished |
| timeout_o | output | 1 | With done_o: ramp-done never seen |
| cfg_err_o | output | 1 | With done_o: unsupported comparison frequency |

## Verification
The bench first sweeps the comparison frequency over every supported code and over a set of unsupported codes. This separates the coefficient lookup from the refusal path. Next it sweeps the delay of ramp_done_i after the ramp-enable write, from zero up to tens of cycles, and compares the exit cycle with the poll-grid arithmetic. That sweep tells apart the synchronizer latency, the poll period and the position of the first poll. Delays just inside and just outside the last poll, along with a ramp that never finishes, separate the success and timeout outcomes. Equal-N requests and start pulses sent while busy show that no writes occur and that a running sequence is not disturbed.

// File: rtl/ndiv_ramp_pkg.sv
package ndiv_ramp_pkg;

    localparam int STEP_W = 8;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ENTER  = 3'd1,
        S_WAIT_N = 3'd2,
        S_WAIT_R = 3'd3,
        S_POLL   = 3'd4,
        S_FIN    = 3'd5
    } ramp_state_e;

endpackage

// File: rtl/ndiv_ramp_tick.sv
// Microsecond time base: one-cycle tick every DIV cycles while run is high.
module ndiv_ramp_tick #(
    parameter int DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/ndiv_ramp_sync.sv
// Multi-flop synchronizer for the asynchronous ramp-done status.
module ndiv_ramp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh_q[0] <= 1'b0;
                    else        sh_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh_q[g] <= 1'b0;
                    else        sh_q[g] <= sh_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/ndiv_ramp_step_lut.sv
// Ramp step coefficients selected by comparison frequency (kHz).
module ndiv_ramp_step_lut
    import ndiv_ramp_pkg::*;
#(
    parameter int FW = 16
) (
    input  logic [FW-1:0]     khz,
    output logic              ok,
    output logic [STEP_W-1:0] step_a,
    output logic [STEP_W-1:0] step_b
);
    always_comb begin
        ok     = 1'b1;
        step_a = '0;
        step_b = '0;
        case (khz)
            FW'(12000), FW'(12800), FW'(13000): begin
                step_a = 8'h2B;
                step_b = 8'h0B;
            end
            FW'(19200): begin
                step_a = 8'h12;
                step_b = 8'h08;
            end
            FW'(38400): begin
                step_a = 8'h04;
                step_b = 8'h05;
            end
            default: ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/ndiv_ramp_ctrl.sv
// Feedback divider ramp sequencer.
module ndiv_ramp_ctrl
    import ndiv_ramp_pkg::*;
#(
    parameter int NW          = 8,
    parameter int FW          = 16,
    parameter int TICK_DIV    = 200,
    parameter int POLL_MAX    = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NW-1:0]     target_n_i,
    input  logic [NW-1:0]     cur_n_i,
    input  logic [FW-1:0]     cmp_khz_i,
    input  logic              ramp_done_i,
    output logic              step_wr_o,
    output logic [STEP_W-1:0] step_a_o,
    output logic [STEP_W-1:0] step_b_o,
    output logic              n_wr_o,
    output logic [NW-1:0]     n_val_o,
    output logic              mode_wr_o,
    output logic              slowdown_o,
    output logic              dynramp_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              cfg_err_o
);
    localparam int PW = $clog2(POLL_MAX + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);

    typedef struct packed {
        ramp_state_e       st;
        logic [NW-1:0]     nval;
        logic [STEP_W-1:0] sa;
        logic [STEP_W-1:0] sb;
        logic [PW-1:0]     polls;
        logic              tmo_flag;
        logic              step_wr;
        logic              n_wr;
        logic              mode_wr;
        logic              slow;
        logic              ramp;
        logic              done;
        logic              tmo;
        logic              cfg_err;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic              tick;
    logic              run;
    logic              done_sync;
    logic              lut_ok;
    logic [STEP_W-1:0] lut_a;
    logic [STEP_W-1:0] lut_b;

    assign run = (r_q.st == S_WAIT_N) || (r_q.st == S_WAIT_R) || (r_q.st == S_POLL);

    ndiv_ramp_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    ndiv_ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ramp_done_i),
        .dout (done_sync)
    );

    ndiv_ramp_step_lut #(.FW(FW)) u_lut (
        .khz   (cmp_khz_i),
        .ok    (lut_ok),
        .step_a(lut_a),
        .step_b(lut_b)
    );

    always_comb begin
        r_d         = r_q;
        r_d.step_wr = 1'b0;
        r_d.n_wr    = 1'b0;
        r_d.mode_wr = 1'b0;
        r_d.done    = 1'b0;
        r_d.tmo     = 1'b0;
        r_d.cfg_err = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (target_n_i == cur_n_i) begin
                        r_d.done = 1'b1;
                    end else if (!lut_ok) begin
                        r_d.done    = 1'b1;
                        r_d.cfg_err = 1'b1;
                    end else begin
                        r_d.st       = S_ENTER;
                        r_d.nval     = target_n_i;
                        r_d.sa       = lut_a;
                        r_d.sb       = lut_b;
                        r_d.polls    = '0;
                        r_d.tmo_flag = 1'b0;
                        r_d.step_wr  = 1'b1;
                    end
                end
            end
            S_ENTER: begin
                r_d.mode_wr = 1'b1;
                r_d.slow    = 1'b1;
                r_d.ramp    = 1'b0;
                r_d.st      = S_WAIT_N;
            end
            S_WAIT_N: begin
                if (tick) begin
                    r_d.n_wr = 1'b1;
                    r_d.st   = S_WAIT_R;
                end
            end
            S_WAIT_R: begin
                if (tick) begin
                    r_d.mode_wr = 1'b1;
                    r_d.slow    = 1'b1;
                    r_d.ramp    = 1'b1;
                    r_d.st      = S_POLL;
                end
            end
            S_POLL: begin
                if (tick) begin
                    if (done_sync || (r_q.polls == POLL_LAST)) begin
                        r_d.tmo_flag = !done_sync;
                        r_d.mode_wr  = 1'b1;
                        r_d.slow     = 1'b0;
                        r_d.ramp     = 1'b0;
                        r_d.st       = S_FIN;
                    end else begin
                        r_d.polls = r_q.polls + 1'b1;
                    end
                end
            end
            S_FIN: begin
                r_d.done = 1'b1;
                r_d.tmo  = r_q.tmo_flag;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign step_wr_o  = r_q.step_wr;
    assign step_a_o   = r_q.sa;
    assign step_b_o   = r_q.sb;
    assign n_wr_o     = r_q.n_wr;
    assign n_val_o    = r_q.nval;
    assign mode_wr_o  = r_q.mode_wr;
    assign slowdown_o = r_q.slow;
    assign dynramp_o  = r_q.ramp;
    assign busy_o     = (r_q.st != S_IDLE);
    assign done_o     = r_q.done;
    assign timeout_o  = r_q.tmo;
    assign cfg_err_o  = r_q.cfg_err;

endmodule

// File: rtl/ndiv_ramp_ctrl_chk.sv
module ndiv_ramp_ctrl_chk #(
    parameter int NW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step_wr_o,
    input logic [7:0]    step_a_o,
    input logic [7:0]    step_b_o,
    input logic          n_wr_o,
    input logic [NW-1:0] n_val_o,
    input logic          mode_wr_o,
    input logic          slowdown_o,
    input logic          dynramp_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          timeout_o,
    input logic          cfg_err_o
);
    p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_wr_o, n_wr_o, mode_wr_o, done_o}));

    p_writes_when_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_wr_o || n_wr_o || mode_wr_o) |-> busy_o);

    p_n_inside_slowdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
        n_wr_o |-> (slowdown_o && !dynramp_o));

    p_ramp_needs_slowdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_o && dynramp_o) |-> slowdown_o);

    p_exit_then_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_o && !slowdown_o) |=> (done_o && !dynramp_o));

    p_timeout_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> done_o);

    p_cfg_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (done_o && !busy_o && !timeout_o));

    p_step_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_wr_o |-> ((step_a_o == 8'h2B && step_b_o == 8'h0B) ||
                       (step_a_o == 8'h12 && step_b_o == 8'h08) ||
                       (step_a_o == 8'h04 && step_b_o == 8'h05)));

    p_n_held_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(n_val_o));

endmodule

bind ndiv_ramp_ctrl ndiv_ramp_ctrl_chk #(.NW(NW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_wr_o (step_wr_o),
    .step_a_o  (step_a_o),
    .step_b_o  (step_b_o),
    .n_wr_o    (n_wr_o),
    .n_val_o   (n_val_o),
    .mode_wr_o (mode_wr_o),
    .slowdown_o(slowdown_o),
    .dynramp_o (dynramp_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/tb_ndiv_ramp_ctrl.sv
`timescale 1ns/1ps
module tb_ndiv_ramp_ctrl;
    localparam int NW = 8;
    localparam int FW = 16;
    localparam int T  = 4;
    localparam int PM = 500;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [NW-1:0] target_n_i = '0;
    logic [NW-1:0] cur_n_i = '0;
    logic [FW-1:0] cmp_khz_i = '0;
    logic          ramp_done_i = 1'b0;
    logic          step_wr_o, n_wr_o, mode_wr_o, slowdown_o, dynramp_o;
    logic          busy_o, done_o, timeout_o, cfg_err_o;
    logic [7:0]    step_a_o, step_b_o;
    logic [NW-1:0] n_val_o;

    ndiv_ramp_ctrl #(.NW(NW), .FW(FW), .TICK_DIV(T), .POLL_MAX(PM), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_n_i(target_n_i),
        .cur_n_i(cur_n_i), .cmp_khz_i(cmp_khz_i), .ramp_done_i(ramp_done_i),
        .step_wr_o(step_wr_o), .step_a_o(step_a_o), .step_b_o(step_b_o),
        .n_wr_o(n_wr_o), .n_val_o(n_val_o), .mode_wr_o(mode_wr_o),
        .slowdown_o(slowdown_o), .dynramp_o(dynramp_o), .busy_o(busy_o),
        .done_o(done_o), .timeout_o(timeout_o), .cfg_err_o(cfg_err_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int c_start, c_step, c_enter, c_n, c_ramp, c_exit, c_done;
    int n_writes, n_dones, mode_bad, stray_tmo;
    int r_a, r_b, r_n;
    bit r_tmo, r_err;
    bit finished = 0;

    // Event recorder, sampling 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        if (step_wr_o) begin c_step = cyc; r_a = step_a_o; r_b = step_b_o; n_writes++; end
        if (n_wr_o) begin c_n = cyc; r_n = n_val_o; n_writes++; end
        if (mode_wr_o) begin
            n_writes++;
            if (slowdown_o && !dynramp_o)      c_enter = cyc;
            else if (slowdown_o && dynramp_o)  c_ramp = cyc;
            else if (!slowdown_o && !dynramp_o) c_exit = cyc;
            else mode_bad++;
        end
        if (done_o) begin c_done = cyc; r_tmo = timeout_o; r_err = cfg_err_o; n_dones++; end
        if (timeout_o && !done_o) stray_tmo++;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        finished = 1;
        $finish;
    endtask

    always @(negedge clk) begin
        if (!finished && cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    function automatic bit exp_step(input int khz, output int a, output int b);
        a = 0; b = 0;
        if (khz == 12000 || khz == 12800 || khz == 13000) begin a = 'h2B; b = 'h0B; return 1; end
        if (khz == 19200) begin a = 'h12; b = 'h08; return 1; end
        if (khz == 38400) begin a = 'h04; b = 'h05; return 1; end
        return 0;
    endfunction

    // One request; dly < 0 means ramp-done never rises.
    task automatic xact(input int tgt, input int cur, input int khz, input int dly, input bit poke);
        c_step = -1; c_enter = -1; c_n = -1; c_ramp = -1; c_exit = -1; c_done = -1;
        n_writes = 0; n_dones = 0; mode_bad = 0; r_tmo = 0; r_err = 0;
        ramp_done_i = 1'b0;
        @(negedge clk);
        target_n_i = NW'(tgt); cur_n_i = NW'(cur); cmp_khz_i = FW'(khz);
        start_i = 1'b1; c_start = cyc;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 5000 && c_done < 0; i++) begin
            if (poke && i == 2) begin start_i = 1'b1; target_n_i = NW'(tgt + 1); end
            else if (poke && i == 3) begin start_i = 1'b0; target_n_i = NW'(tgt); end
            if (dly >= 0 && c_ramp >= 0 && cyc >= c_ramp + dly) ramp_done_i = 1'b1;
            @(negedge clk);
        end
        start_i = 1'b0;
        ramp_done_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Full-ramp checks given the expected outcome.
    task automatic chk_ramp(input int tgt, input int khz, input int dly, input string tag);
        int a, b, j, exp_exit;
        bit tmo;
        void'(exp_step(khz, a, b));
        chk("R2", {tag, " step first"}, c_step, c_start + 1);
        chk("R2", {tag, " step A"}, r_a, a);
        chk("R2", {tag, " step B"}, r_b, b);
        chk("R4", {tag, " enter after step"}, c_enter, c_step + 1);
        chk("R4", {tag, " N after 1us"}, c_n, c_enter + T);
        chk("R4", {tag, " N value"}, r_n, tgt);
        chk("R4", {tag, " ramp after 1us"}, c_ramp, c_n + T);
        if (dly < 0) j = PM + 1;
        else begin
            j = (dly + 3 + T - 1) / T;
            if (j < 1) j = 1;
        end
        tmo = (j > PM);
        exp_exit = tmo ? c_ramp + PM * T : c_ramp + j * T;
        chk(tmo ? "R6" : "R5", {tag, " exit cycle"}, c_exit, exp_exit);
        chk("R6", {tag, " timeout flag"}, r_tmo, tmo);
        chk("R7", {tag, " done after exit"}, c_done, c_exit + 1);
        chk("R7", {tag, " write count"}, n_writes, 5);
        chk("R7", {tag, " mode field combos"}, mode_bad, 0);
        chk("R7", {tag, " stray timeout"}, stray_tmo, 0);
    endtask

    initial begin
        int good_khz [5] = '{12000, 12800, 13000, 19200, 38400};
        int bad_khz  [6] = '{0, 11999, 12001, 19199, 25000, 65535};
        int a, b;
        stray_tmo = 0;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9", "busy in reset", busy_o, 0);
        chk("R9", "strobes in reset", {step_wr_o, n_wr_o, mode_wr_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "fields after reset", {slowdown_o, dynramp_o, timeout_o, cfg_err_o}, 0);
        chk("R9", "values after reset", {step_a_o, step_b_o, n_val_o}, 0);

        // R2/R4/R5: every supported frequency, done immediately available
        foreach (good_khz[k]) begin
            xact(40 + k, 10, good_khz[k], 0, 0);
            chk_ramp(40 + k, good_khz[k], 0, $sformatf("khz %0d", good_khz[k]));
        end

        // R3: unsupported frequencies are refused without writes
        foreach (bad_khz[k]) begin
            xact(90, 30, bad_khz[k], 0, 0);
            chk("R3", "refused done cycle", c_done, c_start + 1);
            chk("R3", "refused error flag", r_err, 1);
            chk("R3", "refused writes", n_writes, 0);
        end

        // R1: equal N, with a good and a bad frequency
        for (int n = 0; n < 256; n += 85) begin
            xact(n, n, 19200, 0, 0);
            chk("R1", "equal N done cycle", c_done, c_start + 1);
            chk("R1", "equal N writes", n_writes, 0);
            chk("R1", "equal N no error", r_err, 0);
            xact(n, n, 12345, 0, 0);
            chk("R1", "equal N bad freq writes", n_writes, 0);
            chk("R1", "equal N bad freq no error", r_err, 0);
        end

        // R5: sweep of ramp-done arrival against the poll grid
        for (int d = 0; d <= 40; d++) begin
            xact(200, 100, 38400, d, 0);
            chk_ramp(200, 38400, d, $sformatf("delay %0d", d));
        end

        // R6: last-poll boundary and timeout
        xact(17, 250, 12800, PM * T - 3, 0);
        chk_ramp(17, 12800, PM * T - 3, "last poll hit");
        xact(17, 250, 12800, PM * T - 2, 0);
        chk_ramp(17, 12800, PM * T - 2, "one past last poll");
        xact(5, 6, 13000, -1, 0);
        chk_ramp(5, 13000, -1, "never done");

        // R8: start while busy is ignored
        xact(123, 7, 19200, 6, 1);
        chk_ramp(123, 19200, 6, "poke while busy");
        chk("R8", "single done", n_dones, 1);
        void'(exp_step(19200, a, b));

        finish_run();
    end

endmodule